// File: doc/BRIEF.md
# Masked-Configuration GPIO Bank Controller

A register-mapped controller for a parameterised number of general-purpose I/O banks. Each bank has 32 lines. The lines are not configured through one register per pin. Software first loads a per-bank line-select mask. A write to the bank's shared configuration slot then updates the function, direction and pull-up of every selected line in a single bus cycle. Reading the same slot returns the configuration of one selected line.

Per-bank set and clear slots update the output latch one bit at a time, without a read-modify-write. A status slot returns the pad levels after a two-flop synchroniser. On the pad side, every line presents its latched output value, an output enable, a pull-up request and a 3-bit function select, and it accepts a raw input level. The pad cells and the peripheral multiplexers that consume the function select sit outside this block.

Bank b occupies a 32-byte window at byte address b*32. Within that window the word slots are: line-select mask at 0x00, configuration at 0x04, set-output at 0x08, clear-output at 0x0C and status at 0x10. The byte-lane bits addr[1:0] are ignored.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A write to the mask slot (0x00) of bank b stores the written 32-bit word as that bank's line-select mask. A read of that slot returns the stored mask.
- R2: A write to the configuration slot (0x04) copies the fields into every line of the bank whose mask bit is 1. All other lines, including every line of the other banks, keep their configuration.
- R3: A read of the configuration slot returns the configuration of the lowest-numbered selected line. It returns 0 when the mask is 0. Reserved bits always read 0, even after they were written with 1s.
- R4: The configuration word has the function in bits [2:0] (0 = GPIO, 1..7 = peripheral A..G), the direction in bit 8 (1 = output) and the pull-up enable in bit 9. Line l of bank b drives pad_func_o[(b*32+l)*3 +: 3] and pad_pu_o[b*32+l] from that line's stored fields. With function 0 and direction 0, the line is a GPIO input.
- R5: pad_oe_o for a line is 1 exactly when its function is 0 and its direction is 1.
- R6: A write to the set-output slot (0x08) makes the output latch 1 for every 1 bit of the written word. Bits written as 0 leave the latch unchanged.
- R7: A write to the clear-output slot (0x0C) makes the output latch 0 for every 1 bit of the written word. Bits written as 0 leave the latch unchanged. pad_out_o presents the latch.
- R8: A read of the status slot (0x10) returns the bank's pad_in_i levels after two synchroniser flops. A read issued on the first edge after a pad change still returns the previous level. A read issued two edges after the change returns the new level.
- R9: An access whose bank index is N_BANKS or higher, or whose slot is not one of the five defined slots, changes no state. Such a read returns 0. The set and clear slots also read as 0.
- R10: While rst_ni is low, every mask, configuration and output latch is 0. As a result, all pad outputs, enables, pull-ups and function selects are 0.
- R11: rdata_o is registered. It takes the read result on the edge that accepts a read and holds it until the next read, even across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (9) | Byte address: bank in [ADDR_W-1:5], slot in [4:2] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | N_BANKS*32 | Raw pad input levels |
| pad_out_o | output | N_BANKS*32 | Output latch value per line |
| pad_oe_o | output | N_BANKS*32 | Output enable per line |
| pad_pu_o | output | N_BANKS*32 | Pull-up enable per line |
| pad_func_o | output | N_BANKS*96 | 3-bit function select per line |

## Verification
A write acts on the edge that accepts it. Masks, configurations, latches and all pad-side outputs therefore show the new value on the following clock low phase. A read result appears on rdata_o one edge after it is accepted. The bench drives every access on the falling edge, sees the outcome of a write on the next falling edge, and samples read data one falling edge after the request.

Status is the exception, because a pad change crosses the two synchroniser flops and then the read register. The bench reads once on the first edge after a change and expects the old level. It then waits one more edge and expects the new level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned LINES_PER_BANK = 32;
  localparam int unsigned FUNC_W         = 3;
  localparam int unsigned SLOT_W         = 3;
  localparam int unsigned WIN_LOG2       = SLOT_W + 2;  // 32-byte window per bank
  localparam int unsigned DIR_BIT        = 8;
  localparam int unsigned PU_BIT         = 9;

  typedef logic [31:0] word_t;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_MASK = 3'd0,
    SLOT_CFG  = 3'd1,
    SLOT_SET  = 3'd2,
    SLOT_CLR  = 3'd3,
    SLOT_STAT = 3'd4
  } slot_e;

  localparam logic [FUNC_W-1:0] FUNC_GPIO = '0;

  typedef struct packed {
    logic              pu;
    logic              dir;
    logic [FUNC_W-1:0] func;
  } line_cfg_t;

  function automatic line_cfg_t cfg_from_word(input word_t w);
    line_cfg_t c;
    c.func = w[FUNC_W-1:0];
    c.dir  = w[DIR_BIT];
    c.pu   = w[PU_BIT];
    return c;
  endfunction

  function automatic word_t cfg_to_word(input line_cfg_t c);
    word_t w;
    w                = '0;
    w[FUNC_W-1:0]    = c.func;
    w[DIR_BIT]       = c.dir;
    w[PU_BIT]        = c.pu;
    return w;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/gpio_cfg_array.sv
module gpio_cfg_array
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = LINES_PER_BANK
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  line_cfg_t                   wcfg_i,
  input  logic      [LINES-1:0]       sel_i,
  output line_cfg_t [LINES-1:0]       cfg_o,
  output line_cfg_t                   rd_cfg_o
);

  line_cfg_t [LINES-1:0] cfg_q;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cfg_q[l] <= '0;
      else if (wr_i && sel_i[l])  cfg_q[l] <= wcfg_i;
    end
  end

  // lowest selected line wins the read-back
  always_comb begin
    rd_cfg_o = '0;
    for (int l = int'(LINES) - 1; l >= 0; l--) begin
      if (sel_i[l]) rd_cfg_o = cfg_q[l];
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = LINES_PER_BANK
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mask_we_i,
  input  logic                    cfg_we_i,
  input  logic                    set_we_i,
  input  logic                    clr_we_i,
  input  word_t                   wdata_i,
  input  logic [LINES-1:0]        pad_in_i,
  output logic [LINES-1:0]        mask_o,
  output word_t                   cfg_rd_o,
  output logic [LINES-1:0]        stat_o,
  output logic [LINES-1:0]        out_o,
  output logic [LINES-1:0]        oe_o,
  output logic [LINES-1:0]        pu_o,
  output logic [LINES*FUNC_W-1:0] func_o
);

  logic      [LINES-1:0] mask_q, latch_q;
  line_cfg_t [LINES-1:0] cfg;
  line_cfg_t             rd_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i[LINES-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       latch_q <= '0;
    else if (set_we_i) latch_q <= latch_q | wdata_i[LINES-1:0];
    else if (clr_we_i) latch_q <= latch_q & ~wdata_i[LINES-1:0];
  end

  gpio_cfg_array #(.LINES(LINES)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_we_i),
    .wcfg_i   (cfg_from_word(wdata_i)),
    .sel_i    (mask_q),
    .cfg_o    (cfg),
    .rd_cfg_o (rd_cfg)
  );

  gpio_in_sync #(.W(LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (stat_o)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_pad
    assign oe_o[l]                     = (cfg[l].func == FUNC_GPIO) && cfg[l].dir;
    assign pu_o[l]                     = cfg[l].pu;
    assign func_o[l*FUNC_W +: FUNC_W]  = cfg[l].func;
  end

  assign mask_o   = mask_q;
  assign out_o    = latch_q;
  assign cfg_rd_o = cfg_to_word(rd_cfg);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned ADDR_W  = 9
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       req_i,
  input  logic                                       we_i,
  input  logic [ADDR_W-1:0]                          addr_i,
  input  logic [31:0]                                wdata_i,
  output logic [31:0]                                rdata_o,
  input  logic [N_BANKS*LINES_PER_BANK-1:0]          pad_in_i,
  output logic [N_BANKS*LINES_PER_BANK-1:0]          pad_out_o,
  output logic [N_BANKS*LINES_PER_BANK-1:0]          pad_oe_o,
  output logic [N_BANKS*LINES_PER_BANK-1:0]          pad_pu_o,
  output logic [N_BANKS*LINES_PER_BANK*FUNC_W-1:0]   pad_func_o
);

  localparam int unsigned LN     = LINES_PER_BANK;
  localparam int unsigned BSEL_W = ADDR_W - WIN_LOG2;

  logic [BSEL_W-1:0] bank_idx;
  slot_e             slot;
  logic              wr_req, rd_req;
  logic              unused_lanes;

  assign bank_idx     = addr_i[ADDR_W-1:WIN_LOG2];
  assign slot         = slot_e'(addr_i[WIN_LOG2-1:2]);
  assign wr_req       = req_i && we_i;
  assign rd_req       = req_i && !we_i;
  assign unused_lanes = ^addr_i[1:0];

  logic  [N_BANKS-1:0] bank_hit;
  logic  [LN-1:0]      mask_b [N_BANKS];
  word_t               cfg_b  [N_BANKS];
  logic  [LN-1:0]      stat_b [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_hit[b] = (bank_idx == BSEL_W'(b));

    gpio_bank #(.LINES(LN)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mask_we_i (wr_req && bank_hit[b] && (slot == SLOT_MASK)),
      .cfg_we_i  (wr_req && bank_hit[b] && (slot == SLOT_CFG)),
      .set_we_i  (wr_req && bank_hit[b] && (slot == SLOT_SET)),
      .clr_we_i  (wr_req && bank_hit[b] && (slot == SLOT_CLR)),
      .wdata_i   (wdata_i),
      .pad_in_i  (pad_in_i[b*LN +: LN]),
      .mask_o    (mask_b[b]),
      .cfg_rd_o  (cfg_b[b]),
      .stat_o    (stat_b[b]),
      .out_o     (pad_out_o[b*LN +: LN]),
      .oe_o      (pad_oe_o[b*LN +: LN]),
      .pu_o      (pad_pu_o[b*LN +: LN]),
      .func_o    (pad_func_o[b*LN*FUNC_W +: LN*FUNC_W])
    );
  end

  word_t rd_word;

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < int'(N_BANKS); b++) begin
      if (bank_hit[b]) begin
        unique case (slot)
          SLOT_MASK: rd_word = word_t'(mask_b[b]);
          SLOT_CFG:  rd_word = cfg_b[b];
          SLOT_STAT: rd_word = word_t'(stat_b[b]);
          default:   rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rd_req) rdata_o <= rd_word;
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned ADDR_W  = 9
) (
  input logic                                     clk_i,
  input logic                                     rst_ni,
  input logic                                     req_i,
  input logic                                     we_i,
  input logic [ADDR_W-1:0]                        addr_i,
  input logic [31:0]                              wdata_i,
  input logic [31:0]                              rdata_o,
  input logic [N_BANKS*LINES_PER_BANK-1:0]        pad_out_o,
  input logic [N_BANKS*LINES_PER_BANK-1:0]        pad_oe_o,
  input logic [N_BANKS*LINES_PER_BANK-1:0]        pad_pu_o,
  input logic [N_BANKS*LINES_PER_BANK*FUNC_W-1:0] pad_func_o
);

  localparam int unsigned LN     = LINES_PER_BANK;
  localparam int unsigned BSEL_W = ADDR_W - WIN_LOG2;
  localparam logic [BSEL_W:0] NB_L = (BSEL_W+1)'(N_BANKS);

  logic [BSEL_W-1:0]   bank;
  logic [SLOT_W-1:0]   slot;
  logic                unused_lo;

  assign bank      = addr_i[ADDR_W-1:WIN_LOG2];
  assign slot      = addr_i[WIN_LOG2-1:2];
  assign unused_lo = ^addr_i[1:0];

  for (genvar i = 0; i < N_BANKS*LN; i++) begin : g_line
    // R5
    oe_gpio_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_oe_o[i] |-> (pad_func_o[i*FUNC_W +: FUNC_W] == FUNC_GPIO));
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    // R6
    set_drives_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && bank == BSEL_W'(b) && slot == SLOT_SET)
      |=> ((pad_out_o[b*LN +: LN] & $past(wdata_i)) == $past(wdata_i)));
    // R7
    clr_drives_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && bank == BSEL_W'(b) && slot == SLOT_CLR)
      |=> ((pad_out_o[b*LN +: LN] & $past(wdata_i)) == '0));
  end

  // R9
  stray_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && {1'b0, bank} >= NB_L) |=> (rdata_o == '0));

  // R2
  idle_pads_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(pad_func_o) && $stable(pad_pu_o)
                          && $stable(pad_out_o) && $stable(pad_oe_o)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R10
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_out_o == '0 && pad_oe_o == '0 && pad_pu_o == '0
                 && pad_func_o == '0 && rdata_o == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.N_BANKS(N_BANKS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;

  localparam int NB = 4;
  localparam int NL = 32;
  localparam int NP = NB*NL;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [8:0]        addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NP-1:0]     pad_in_i = '0;
  logic [NP-1:0]     pad_out_o, pad_oe_o, pad_pu_o;
  logic [NP*3-1:0]   pad_func_o;

  always #5 clk_i = ~clk_i;

  gpio_bank_ctrl #(.N_BANKS(NB), .ADDR_W(9)) u0 (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_mask [NB];
  logic [31:0] m_out  [NB];
  logic [2:0]  m_func [NB][NL];
  logic        m_dir  [NB][NL];
  logic        m_pu   [NB][NL];

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] ad(input int b, input int s);
    return 9'(b*32 + s*4);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_mask[b] = '0; m_out[b] = '0;
      for (int l = 0; l < NL; l++) begin
        m_func[b][l] = '0; m_dir[b][l] = 1'b0; m_pu[b][l] = 1'b0;
      end
    end
  endtask

  task automatic bus(input logic w, input logic [8:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    bus(1'b0, a, '0);
    chk(tag, 512'(rdata_o), 512'(exp));
  endtask

  task automatic set_mask(input int b, input logic [31:0] m);
    bus(1'b1, ad(b, 0), m);
    m_mask[b] = m;
  endtask

  task automatic write_cfg(input int b, input logic [31:0] w);
    bus(1'b1, ad(b, 1), w);
    for (int l = 0; l < NL; l++)
      if (m_mask[b][l]) begin
        m_func[b][l] = w[2:0]; m_dir[b][l] = w[8]; m_pu[b][l] = w[9];
      end
  endtask

  task automatic set_out(input int b, input logic [31:0] m);
    bus(1'b1, ad(b, 2), m);
    m_out[b] = m_out[b] | m;
  endtask

  task automatic clr_out(input int b, input logic [31:0] m);
    bus(1'b1, ad(b, 3), m);
    m_out[b] = m_out[b] & ~m;
  endtask

  function automatic logic [31:0] exp_cfg(input int b);
    for (int l = 0; l < NL; l++)
      if (m_mask[b][l])
        return {22'd0, m_pu[b][l], m_dir[b][l], 5'd0, m_func[b][l]};
    return '0;
  endfunction

  task automatic check_pads(input string tag);
    logic [NP-1:0]   e_out, e_oe, e_pu;
    logic [NP*3-1:0] e_func;
    for (int b = 0; b < NB; b++) begin
      e_out[b*NL +: NL] = m_out[b];
      for (int l = 0; l < NL; l++) begin
        e_oe[b*NL+l]          = (m_func[b][l] == 3'd0) && m_dir[b][l];
        e_pu[b*NL+l]          = m_pu[b][l];
        e_func[(b*NL+l)*3 +: 3] = m_func[b][l];
      end
    end
    chk({tag, " pad_out"},  512'(pad_out_o),  512'(e_out));
    chk({tag, " pad_oe"},   512'(pad_oe_o),   512'(e_oe));
    chk({tag, " pad_pu"},   512'(pad_pu_o),   512'(e_pu));
    chk({tag, " pad_func"}, 512'(pad_func_o), 512'(e_func));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    repeat (3) @(negedge clk_i);
    // R10: outputs cleared while reset is held
    check_pads("R10 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_pads("R10 after reset");
    for (int b = 0; b < NB; b++) begin
      rd_chk("R10 mask", ad(b, 0), '0);
      rd_chk("R10 cfg", ad(b, 1), '0);
    end

    // R1: mask store and read-back sweep
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 6; k++) begin
        logic [31:0] m;
        m = (32'hA5C3_0F96 ^ (32'h1111_1111 * k)) + 32'(b);
        set_mask(b, m);
        rd_chk("R1 mask readback", ad(b, 0), m);
      end

    // R2 R3 R4 R5: broadcast writes over all function codes
    for (int b = 0; b < NB; b++)
      for (int f = 0; f < 8; f++) begin
        logic [31:0] m, w;
        m = (32'h1 << (f*3 + b)) | (32'h8000_0000 >> f) | (32'h0001_0000 << f);
        w = 32'(f) | (32'(f & 1) << 8) | (32'((f >> 1) & 1) << 9) | 32'h5A5A_5878;
        set_mask(b, m);
        write_cfg(b, w);
        check_pads("R2 broadcast");
        rd_chk("R3 lowest selected", ad(b, 1), exp_cfg(b));
      end

    // R3: empty mask reads 0
    set_mask(2, 32'h0);
    rd_chk("R3 empty mask", ad(2, 1), 32'h0);

    // R3: lowest of many selected lines
    set_mask(1, 32'h0000_0100);
    write_cfg(1, 32'h0000_0206);
    set_mask(1, 32'hFFFF_FF00);
    rd_chk("R3 multi select", ad(1, 1), 32'h0000_0206);

    // R5: GPIO output enables, peripheral function drops enable
    set_mask(1, 32'hFFFF_FFFF);
    write_cfg(1, 32'h0000_0100);
    check_pads("R5 gpio out");
    write_cfg(1, 32'h0000_0105);
    check_pads("R5 periph dir1");
    // R4: clearing function and direction leaves GPIO input
    write_cfg(1, 32'h0000_0000);
    check_pads("R4 gpio input");
    rd_chk("R4 cfg word", ad(1, 1), 32'h0);

    // R6 R7: set and clear sweep, zero writes are no-ops
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 5; k++) begin
        set_out(b, 32'h0F0F_3C3C << k);
        check_pads("R6 set");
        clr_out(b, 32'h1248_8421 << (k + b));
        check_pads("R7 clear");
        set_out(b, 32'h0);
        clr_out(b, 32'h0);
        check_pads("R7 zero write no effect");
      end

    // R8: status synchroniser latency
    for (int k = 0; k < 4; k++) begin
      logic [NP-1:0] prev, nxt;
      prev = pad_in_i;
      nxt  = {4{32'hDEAD_BEEF ^ (32'h0101_0101 << k)}} ^ NP'(k*32'h77);
      pad_in_i = nxt;
      rd_chk("R8 first edge old level", ad(k, 4), prev[k*NL +: NL]);
      @(negedge clk_i);
      for (int b = 0; b < NB; b++)
        rd_chk("R8 synced level", ad(b, 4), nxt[b*NL +: NL]);
    end

    // R9: out-of-range bank and undefined slots
    for (int b = NB; b < 16; b++) begin
      bus(1'b1, ad(b, 2), 32'hFFFF_FFFF);
      bus(1'b1, ad(b, 1), 32'h0000_0307);
      rd_chk("R9 stray bank read", ad(b, 4), 32'h0);
    end
    bus(1'b1, ad(0, 5), 32'hFFFF_FFFF);
    bus(1'b1, ad(0, 7), 32'hFFFF_FFFF);
    check_pads("R9 ignored writes");
    rd_chk("R9 slot5", ad(0, 5), 32'h0);
    rd_chk("R9 set slot", ad(3, 2), 32'h0);
    rd_chk("R9 clr slot", ad(3, 3), 32'h0);

    // R11: read data held across writes
    set_mask(3, 32'h1357_9BDF);
    rd_chk("R11 read", ad(3, 0), 32'h1357_9BDF);
    set_mask(3, 32'h0);
    set_out(3, 32'hFFFF_0000);
    chk("R11 hold", 512'(rdata_o), 512'(32'h1357_9BDF));

    // R10: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    check_pads("R10 re-reset");
    chk("R10 rdata", 512'(rdata_o), 512'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule